// File: doc/BRIEF.md
# Addressable Parallel Slave Port

This block gives an external bus master access to two small banks of byte-wide buffers. It does this through an asynchronous 8-bit parallel slave bus that has a chip select, separate read and write strobes, and a 2-bit address. All strobes are active high. The external master reads from a bank of read buffers that the on-chip host fills. It writes into a bank of write buffers that the on-chip host collects. Each read buffer carries an empty flag and each write buffer carries a full flag, so both sides can tell which entries still hold data that has not been consumed.

The block has two selection schemes. In addressable mode the external 2-bit address picks the buffer. In sequential mode, separate read and write pointers walk through the buffers and wrap back to buffer 0 after buffer 3. The strobes and chip select pass through a two-flop synchroniser. An access is taken when the synchronised strobe is released while chip select was active. A configurable interrupt then fires as a single-cycle pulse on the internal clock.

Top module: `pslave_port`

## Requirements
- R1: After reset all four write-buffer full flags are 0, all four read-buffer empty flags are 1, `irq` is 0, and both sequential pointers point at buffer 0.
- R2: `ext_oe` is high exactly while `ext_cs` and `ext_rd` are both high. During that time `ext_dout` carries the selected read buffer.
- R3: When `cfg_addressable` is 1, `ext_addr` selects the buffer for both external reads and external writes, and the sequential pointers do not move.
- R4: When `cfg_addressable` is 0, the read pointer and the write pointer each advance by one on every completed access of their own kind, wrapping from 3 to 0.
- R5: A completed external write stores `ext_din` into the selected write buffer and sets its full flag. A `host_take_en` pulse clears the full flag of `host_take_idx`, and `host_take_data` always shows that buffer. If both hit the same buffer in the same cycle, the flag stays set.
- R6: A completed external read sets the empty flag of the buffer it read. A `host_load_en` pulse stores `host_load_data` into read buffer `host_load_idx` and clears its empty flag. If both hit the same buffer in the same cycle, the flag ends up cleared.
- R7: An access completes when the strobe is released while chip select is high. Its effects on flags and `irq` appear after the third rising clock edge that follows the release. Address and data must be held until then. A strobe pulse with chip select low has no effect.
- R8: With `cfg_irq_mode` = 01, every completed access produces a one-cycle `irq` pulse, and that pulse comes in the same cycle as the flag update.
- R9: With `cfg_irq_mode` = 11, `irq` pulses only for a completed access to buffer 3, whether that buffer was reached by address or by pointer.
- R10: With `cfg_irq_mode` = 00 or 10, `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_cs | input | 1 | External chip select, active high |
| ext_rd | input | 1 | External read strobe, active high |
| ext_wr | input | 1 | External write strobe, active high |
| ext_addr | input | 2 | External buffer address |
| ext_din | input | 8 | Data from the external master |
| ext_dout | output | 8 | Data to the external master |
| ext_oe | output | 1 | Output enable for the external data pads |
| cfg_addressable | input | 1 | 1 = address selects buffer, 0 = sequential pointers |
| cfg_irq_mode | input | 2 | 00 none, 01 every access, 10 none, 11 buffer 3 only |
| host_load_en | input | 1 | Host writes a read buffer |
| host_load_idx | input | 2 | Read buffer to load |
| host_load_data | input | 8 | Byte to load |
| host_take_en | input | 1 | Host consumes a write buffer |
| host_take_idx | input | 2 | Write buffer to view or consume |
| host_take_data | output | 8 | Content of write buffer `host_take_idx` |
| rbuf_empty | output | 4 | Per read buffer: already read by the external master |
| wbuf_full | output | 4 | Per write buffer: holds data not yet taken |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
The hardest case to reach from the ports is a host action that lands in exactly the same clock cycle as the synchronised completion of an external access to the same buffer. The priority rules of R5 and R6 only show up in that cycle. The stimulus counts from the negedge at which the strobe is released and raises the host enable two negedges later, so that both act on the third rising edge. The reference model tracks every flag cycle by cycle, so any shift of one cycle in the synchroniser shows up as a mismatch.

// File: rtl/pslave_pkg.sv
package pslave_pkg;

  typedef enum logic [1:0] {
    IRQ_NONE  = 2'b00,
    IRQ_EVERY = 2'b01,
    IRQ_QUIET = 2'b10,
    IRQ_LAST  = 2'b11
  } irq_mode_e;

  // sequential pointer step with wrap at the bank size
  function automatic int unsigned ptr_step(input int unsigned p, input int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  // decides whether an access to buffer idx raises the interrupt
  function automatic logic irq_fire(input irq_mode_e m, input int unsigned idx,
                                    input int unsigned n);
    case (m)
      IRQ_EVERY: return 1'b1;
      IRQ_LAST:  return idx == n - 1;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pslave_sync.sv
module pslave_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [STAGES:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= async_in;
  end

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= '0;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign sync_o = pipe[STAGES-1];
  assign prev_o = pipe[STAGES];
endmodule

// File: rtl/pslave_bank.sv
module pslave_bank #(
  parameter int DW   = 8,
  parameter int NBUF = 4,
  localparam int AW  = $clog2(NBUF)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fill_en,
  input  logic [AW-1:0]   fill_idx,
  input  logic [DW-1:0]   fill_data,
  input  logic            drain_en,
  input  logic [AW-1:0]   drain_idx,
  input  logic [AW-1:0]   view_idx,
  output logic [DW-1:0]   view_data,
  output logic [NBUF-1:0] holds
);
  logic [NBUF-1:0][DW-1:0] mem;

  for (genvar g = 0; g < NBUF; g++) begin : g_entry
    logic hit_fill, hit_drain;
    assign hit_fill  = fill_en  && (fill_idx  == AW'(g));
    assign hit_drain = drain_en && (drain_idx == AW'(g));

    // producer wins over consumer in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         holds[g] <= 1'b0;
      else if (hit_fill)  holds[g] <= 1'b1;
      else if (hit_drain) holds[g] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mem[g] <= '0;
      else if (hit_fill) mem[g] <= fill_data;
    end
  end

  assign view_data = mem[view_idx];
endmodule

// File: rtl/pslave_irq.sv
module pslave_irq #(
  parameter int NBUF = 4,
  localparam int AW  = $clog2(NBUF)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pslave_pkg::irq_mode_e mode,
  input  logic                 rd_evt,
  input  logic [AW-1:0]        rd_idx,
  input  logic                 wr_evt,
  input  logic [AW-1:0]        wr_idx,
  output logic                 irq
);
  import pslave_pkg::*;
  logic fire;

  always_comb begin
    fire = 1'b0;
    if (rd_evt && irq_fire(mode, int'(rd_idx), NBUF)) fire = 1'b1;
    if (wr_evt && irq_fire(mode, int'(wr_idx), NBUF)) fire = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= fire;
  end
endmodule

// File: rtl/pslave_port.sv
module pslave_port #(
  parameter int DW     = 8,
  parameter int NBUF   = 4,
  parameter int STAGES = 2,
  localparam int AW    = $clog2(NBUF)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_cs,
  input  logic            ext_rd,
  input  logic            ext_wr,
  input  logic [AW-1:0]   ext_addr,
  input  logic [DW-1:0]   ext_din,
  output logic [DW-1:0]   ext_dout,
  output logic            ext_oe,
  input  logic            cfg_addressable,
  input  logic [1:0]      cfg_irq_mode,
  input  logic            host_load_en,
  input  logic [AW-1:0]   host_load_idx,
  input  logic [DW-1:0]   host_load_data,
  input  logic            host_take_en,
  input  logic [AW-1:0]   host_take_idx,
  output logic [DW-1:0]   host_take_data,
  output logic [NBUF-1:0] rbuf_empty,
  output logic [NBUF-1:0] wbuf_full,
  output logic            irq
);
  import pslave_pkg::*;

  localparam int B_RD = 0;
  localparam int B_WR = 1;
  localparam int B_CS = 2;

  logic [2:0] strb_sync, strb_prev;
  logic       rd_evt, wr_evt;
  logic [AW-1:0] rd_ptr, wr_ptr, rd_idx, wr_idx;
  logic [NBUF-1:0] rd_holds;

  pslave_sync #(.STAGES(STAGES), .W(3)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ext_cs, ext_wr, ext_rd}),
    .sync_o   (strb_sync),
    .prev_o   (strb_prev)
  );

  // completion: synchronised strobe falls, chip select seen with its last high sample
  assign rd_evt = strb_prev[B_RD] && !strb_sync[B_RD] && strb_prev[B_CS];
  assign wr_evt = strb_prev[B_WR] && !strb_sync[B_WR] && strb_prev[B_CS];

  assign rd_idx = cfg_addressable ? ext_addr : rd_ptr;
  assign wr_idx = cfg_addressable ? ext_addr : wr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else if (!cfg_addressable) begin
      if (rd_evt) rd_ptr <= AW'(ptr_step(int'(rd_ptr), NBUF));
      if (wr_evt) wr_ptr <= AW'(ptr_step(int'(wr_ptr), NBUF));
    end
  end

  pslave_bank #(.DW(DW), .NBUF(NBUF)) u_rbank (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_en   (host_load_en),
    .fill_idx  (host_load_idx),
    .fill_data (host_load_data),
    .drain_en  (rd_evt),
    .drain_idx (rd_idx),
    .view_idx  (rd_idx),
    .view_data (ext_dout),
    .holds     (rd_holds)
  );

  pslave_bank #(.DW(DW), .NBUF(NBUF)) u_wbank (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_en   (wr_evt),
    .fill_idx  (wr_idx),
    .fill_data (ext_din),
    .drain_en  (host_take_en),
    .drain_idx (host_take_idx),
    .view_idx  (host_take_idx),
    .view_data (host_take_data),
    .holds     (wbuf_full)
  );

  assign rbuf_empty = ~rd_holds;
  assign ext_oe     = ext_cs && ext_rd;

  pslave_irq #(.NBUF(NBUF)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (irq_mode_e'(cfg_irq_mode)),
    .rd_evt (rd_evt),
    .rd_idx (rd_idx),
    .wr_evt (wr_evt),
    .wr_idx (wr_idx),
    .irq    (irq)
  );
endmodule

// File: rtl/pslave_port_chk.sv
module pslave_port_chk #(
  parameter int NBUF = 4,
  localparam int AW  = $clog2(NBUF)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_addressable,
  input logic [1:0]      cfg_irq_mode,
  input logic            host_load_en,
  input logic [AW-1:0]   host_load_idx,
  input logic [NBUF-1:0] rbuf_empty,
  input logic [NBUF-1:0] wbuf_full,
  input logic            irq,
  input logic            rd_evt,
  input logic            wr_evt,
  input logic [AW-1:0]   rd_idx,
  input logic [AW-1:0]   wr_idx,
  input logic [AW-1:0]   wr_ptr
);
  AST_FULL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> wbuf_full[$past(wr_idx)]); // R5

  AST_EMPTY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt && !(host_load_en && host_load_idx == rd_idx) |=> rbuf_empty[$past(rd_idx)]); // R6

  AST_LOAD_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    host_load_en |=> !rbuf_empty[$past(host_load_idx)]); // R6

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt && !host_load_en |=> $stable(rbuf_empty)); // R6

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(rd_evt || wr_evt)); // R8

  AST_IRQ_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_irq_mode[0]) |-> !irq); // R10

  AST_WPTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt && !cfg_addressable && wr_ptr == AW'(NBUF - 1) |=> wr_ptr == '0); // R4
endmodule

bind pslave_port pslave_port_chk #(.NBUF(NBUF)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_addressable (cfg_addressable),
  .cfg_irq_mode    (cfg_irq_mode),
  .host_load_en    (host_load_en),
  .host_load_idx   (host_load_idx),
  .rbuf_empty      (rbuf_empty),
  .wbuf_full       (wbuf_full),
  .irq             (irq),
  .rd_evt          (rd_evt),
  .wr_evt          (wr_evt),
  .rd_idx          (rd_idx),
  .wr_idx          (wr_idx),
  .wr_ptr          (wr_ptr)
);

// File: tb/pslave_port_tb_top.sv
module pslave_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic ext_cs = 0, ext_rd = 0, ext_wr = 0;
  logic [1:0] ext_addr = 0;
  logic [7:0] ext_din = 0;
  logic [7:0] ext_dout;
  logic ext_oe;
  logic cfg_addressable = 1;
  logic [1:0] cfg_irq_mode = 0;
  logic host_load_en = 0, host_take_en = 0;
  logic [1:0] host_load_idx = 0, host_take_idx = 0;
  logic [7:0] host_load_data = 0;
  logic [7:0] host_take_data;
  logic [3:0] rbuf_empty, wbuf_full;
  logic irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  pslave_port dut_i (
    .clk(clk), .rst_n(rst_n), .ext_cs(ext_cs), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .ext_addr(ext_addr), .ext_din(ext_din), .ext_dout(ext_dout), .ext_oe(ext_oe),
    .cfg_addressable(cfg_addressable), .cfg_irq_mode(cfg_irq_mode),
    .host_load_en(host_load_en), .host_load_idx(host_load_idx),
    .host_load_data(host_load_data), .host_take_en(host_take_en),
    .host_take_idx(host_take_idx), .host_take_data(host_take_data),
    .rbuf_empty(rbuf_empty), .wbuf_full(wbuf_full), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit running = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model state
  bit [7:0] m_rb[4], m_wb[4];
  bit m_full[4], m_empty[4];
  int m_rptr = 0, m_wptr = 0;
  int rd_cd = 0, wr_cd = 0, rd_i = 0, wr_i = 0;
  bit [7:0] wr_d;
  bit rd_seq, wr_seq, m_irq = 0;

  function automatic bit fires(int idx);
    if (cfg_irq_mode == 2'b01) return 1;
    if (cfg_irq_mode == 2'b11) return idx == 3;
    return 0;
  endfunction

  initial for (int i = 0; i < 4; i++) begin
    m_rb[i] = 0; m_wb[i] = 0; m_full[i] = 0; m_empty[i] = 1;
  end

  always @(posedge clk) if (rst_n) begin
    bit do_rd, do_wr;
    do_rd = 0; do_wr = 0;
    if (rd_cd > 0) begin rd_cd--; do_rd = (rd_cd == 0); end
    if (wr_cd > 0) begin wr_cd--; do_wr = (wr_cd == 0); end
    m_irq = (do_rd && fires(rd_i)) || (do_wr && fires(wr_i));
    // consumers first, producers last: a producer wins a same-cycle clash
    if (do_rd) begin
      m_empty[rd_i] = 1;
      if (rd_seq) m_rptr = (m_rptr + 1) % 4;
    end
    if (host_take_en) m_full[host_take_idx] = 0;
    if (host_load_en) begin
      m_empty[host_load_idx] = 0;
      m_rb[host_load_idx] = host_load_data;
    end
    if (do_wr) begin
      m_full[wr_i] = 1;
      m_wb[wr_i] = wr_d;
      if (wr_seq) m_wptr = (m_wptr + 1) % 4;
    end
  end

  always @(negedge clk) if (running) begin
    string itag;
    itag = (cfg_irq_mode == 2'b01) ? "R8" : (cfg_irq_mode == 2'b11) ? "R9" : "R10";
    for (int i = 0; i < 4; i++) begin
      check(wbuf_full[i] == m_full[i], "R5/R7", $sformatf("full[%0d]", i),
            int'(wbuf_full[i]), int'(m_full[i]));
      check(rbuf_empty[i] == m_empty[i], "R6/R7", $sformatf("empty[%0d]", i),
            int'(rbuf_empty[i]), int'(m_empty[i]));
    end
    check(irq == m_irq, itag, "irq", int'(irq), int'(m_irq));
  end

  // one external access; clash=1 fires the matching host action on the completion edge
  task automatic ext_access(input bit is_wr, input int a, input bit [7:0] d, input bit clash);
    int idx;
    @(negedge clk);
    ext_addr = 2'(a); ext_din = d; ext_cs = 1;
    if (is_wr) ext_wr = 1; else ext_rd = 1;
    idx = cfg_addressable ? a : (is_wr ? m_wptr : m_rptr);
    @(negedge clk);
    if (!is_wr) begin
      check(ext_oe == 1, "R2", "oe during read", int'(ext_oe), 1);
      check(ext_dout == m_rb[idx], cfg_addressable ? "R3" : "R4", "read data",
            int'(ext_dout), int'(m_rb[idx]));
    end
    @(negedge clk);
    if (is_wr) begin ext_wr = 0; wr_i = idx; wr_d = d; wr_seq = !cfg_addressable; wr_cd = 3; end
    else       begin ext_rd = 0; rd_i = idx; rd_seq = !cfg_addressable; rd_cd = 3; end
    @(negedge clk);
    @(negedge clk);
    if (clash) begin
      if (is_wr) begin host_take_en = 1; host_take_idx = 2'(idx); end
      else begin host_load_en = 1; host_load_idx = 2'(idx); host_load_data = 8'hC3; end
    end
    @(negedge clk);
    host_take_en = 0; host_load_en = 0;
    @(negedge clk);
    ext_cs = 0;
    @(negedge clk);
  endtask

  task automatic host_load(input int i, input bit [7:0] d);
    @(negedge clk);
    host_load_en = 1; host_load_idx = 2'(i); host_load_data = d;
    @(negedge clk);
    host_load_en = 0;
  endtask

  task automatic host_take(input int i, input string req);
    @(negedge clk);
    host_take_idx = 2'(i);
    #1;
    check(host_take_data == m_wb[i], req, $sformatf("take data[%0d]", i),
          int'(host_take_data), int'(m_wb[i]));
    host_take_en = 1;
    @(negedge clk);
    host_take_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    running = 1;
    @(negedge clk);
    // R1 reset state
    check(wbuf_full == 4'b0000, "R1", "full after reset", int'(wbuf_full), 0);
    check(rbuf_empty == 4'b1111, "R1", "empty after reset", int'(rbuf_empty), 15);
    check(irq == 0, "R1", "irq after reset", int'(irq), 0);

    // addressable, every-access interrupt (R3, R8)
    cfg_addressable = 1; cfg_irq_mode = 2'b01;
    for (int i = 0; i < 4; i++) host_load(i, 8'(8'h10 + 8'(i) * 8'h11));
    ext_access(0, 2, 0, 0);
    ext_access(1, 1, 8'h5A, 0);
    host_take(1, "R3");
    ext_access(1, 3, 8'hA7, 0);
    host_take(3, "R5");

    // strobe without chip select is ignored (R7)
    @(negedge clk);
    ext_addr = 0; ext_rd = 1; ext_wr = 0;
    @(negedge clk);
    check(ext_oe == 0, "R2", "oe without cs", int'(ext_oe), 0);
    ext_rd = 0; ext_wr = 1; ext_din = 8'hEE;
    @(negedge clk);
    ext_wr = 0;
    repeat (5) @(negedge clk);
    check(wbuf_full[0] == 0, "R7", "write without cs", int'(wbuf_full[0]), 0);

    // last-buffer interrupt, addressable (R9)
    cfg_irq_mode = 2'b11;
    ext_access(0, 0, 0, 0);
    ext_access(1, 3, 8'h33, 0);
    ext_access(0, 3, 0, 0);

    // sequential mode with wrap (R4, R9): pointers still at 0 from reset (R1, R3)
    cfg_addressable = 0;
    for (int k = 0; k < 5; k++) ext_access(1, 0, 8'(8'h80 + k), 0);
    for (int i = 0; i < 4; i++) host_take(i, "R4");
    for (int i = 0; i < 4; i++) host_load(i, 8'(8'h40 + i));
    for (int k = 0; k < 5; k++) ext_access(0, 0, 0, 0);

    // muted interrupt modes (R10)
    cfg_addressable = 1;
    cfg_irq_mode = 2'b00;
    ext_access(1, 3, 8'h01, 0);
    ext_access(0, 3, 0, 0);
    cfg_irq_mode = 2'b10;
    ext_access(1, 3, 8'h02, 0);
    ext_access(0, 1, 0, 0);

    // same-cycle clashes (R5 producer wins, R6 load wins)
    cfg_irq_mode = 2'b01;
    ext_access(1, 2, 8'h9C, 1);
    check(wbuf_full[2] == 1, "R5", "full kept on clash", int'(wbuf_full[2]), 1);
    host_take(2, "R5");
    ext_access(0, 1, 0, 1);
    check(rbuf_empty[1] == 0, "R6", "empty cleared on clash", int'(rbuf_empty[1]), 0);
    ext_access(0, 1, 0, 0);

    repeat (3) @(negedge clk);
    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule